// File: doc/BRIEF.md
# PHY Interrupt Status Register

This block holds the interrupt status word of a PHY management register space. Eight event monitors (speed, link, duplex, auto-negotiation error, auto-negotiation done, inline-power detect, speed downshift, master/slave resolution fault) each send a one-cycle pulse. The block latches each pulse into its own sticky cause bit. A summary bit shows that at least one cause is pending, and an active-low interrupt line follows that summary.

A management agent reads the word through a simple strobe-and-address port. The data comes back combinationally in the same cycle as the strobe. At the clock edge that ends the read, every latched cause bit clears. Three causes are qualified by configuration held elsewhere. The speed and duplex causes can latch only while auto-negotiation is enabled. The downshift cause can latch only while the four-bit advertised-ability field is all ones.

Top module: `irq_status_reg`

## Requirements
- R1: After synchronous reset, every latched bit is 0, a read of address 26 returns 16'h0000 and `irqN` is 1.
- R2: A qualified pulse on `evtPulse[i]` sets its cause bit at the next rising edge. The bit then stays set until a clearing read. The mapping is index 0 to bit 14 (speed), 1 to bit 13 (link), 2 to bit 12 (duplex), 3 to bit 11 (negotiation error), 4 to bit 10 (negotiation done), 5 to bit 9 (inline power), 6 to bit 2 (downshift) and 7 to bit 0 (master/slave fault).
- R3: While `rdStrobe` is 1 and `rdAddr` equals 26, `rdData` shows the latched word in the same cycle. In every other cycle `rdData` is 16'h0000.
- R4: A read of address 26 clears every set cause bit at its closing edge. A strobe with any other address clears nothing.
- R5: A qualified pulse that arrives in the same cycle as a clearing read is still latched after that edge.
- R6: Bit 15 of the word is 1 exactly when any cause bit (14:0) is latched.
- R7: Pulses on indices 0 and 2 (speed, duplex) are ignored while `anegEnable` is 0.
- R8: A pulse on index 6 (downshift) is ignored unless `advAbility` is 4'b1111.
- R9: Bits 8:3 and bit 1 of the word always read 0.
- R10: `irqN` is 0 exactly while bit 15 of the latched word is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| evtPulse | input | 8 | One-cycle event pulses from the monitors |
| anegEnable | input | 1 | Auto-negotiation enable from the control register |
| advAbility | input | 4 | Advertised-ability field from the advertisement register |
| rdStrobe | input | 1 | Management read strobe |
| rdAddr | input | 5 | Management register address |
| rdData | output | 16 | Read data, valid in the strobe cycle |
| irqN | output | 1 | Interrupt request, active low |

## Verification
Read data is combinational, so the bench compares `rdData` in the same cycle that it drives the strobe. It samples a few nanoseconds after its falling-edge drive. An event pulse or a clearing read takes effect at the next rising edge. The bench therefore updates its expected word only after that cycle's comparison. `irqN` and the word seen by the next read are checked one cycle after the stimulus that changed them. Directed sequences cover a read that coincides with an event, a strobe to the wrong address and the two gating conditions. Seeded random traffic then mixes these conditions.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_EVT = 8;
  localparam int DATA_W  = 16;

  // Events qualified by auto-negotiation enable (speed, duplex).
  localparam logic [NUM_EVT-1:0] ANEG_GATED = 8'b0000_0101;
  // Events qualified by a full advertised-ability field (downshift).
  localparam logic [NUM_EVT-1:0] ABIL_GATED = 8'b0100_0000;

  // Word bit position of each event index.
  localparam int BIT_POS [NUM_EVT] = '{14, 13, 12, 11, 10, 9, 2, 0};
  localparam int SUMMARY_BIT = 15;

  typedef struct packed {
    logic               readHit;
    logic [NUM_EVT-1:0] evtGate;
  } ctrlStrobeT;

  function automatic logic [DATA_W-1:0] packWord(input logic [NUM_EVT-1:0] causes);
    logic [DATA_W-1:0] word;
    word = '0;
    for (int i = 0; i < NUM_EVT; i++) word[BIT_POS[i]] = causes[i];
    word[SUMMARY_BIT] = |causes;
    return word;
  endfunction
endpackage

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl
  import irq_status_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 26,
  parameter int ABIL_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rdStrobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              anegEnable,
  input  logic [ABIL_W-1:0] advAbility,
  output ctrlStrobeT        strobes
);
  logic abilFull;

  always_comb begin
    abilFull        = &advAbility;
    strobes.readHit = rdStrobe && (rdAddr == ADDR_W'(REG_ADDR));
    for (int i = 0; i < NUM_EVT; i++) begin
      strobes.evtGate[i] = (!ANEG_GATED[i] || anegEnable) &&
                           (!ABIL_GATED[i] || abilFull);
    end
  end

  // R7: speed and duplex gates closed while auto-negotiation is off
  a_r7_aneg_gate: assert property (@(posedge clk) disable iff (rst)
    !anegEnable |-> !strobes.evtGate[0] && !strobes.evtGate[2]);

  // R8: downshift gate closed unless the ability field is complete
  a_r8_abil_gate: assert property (@(posedge clk) disable iff (rst)
    (advAbility != '1) |-> !strobes.evtGate[6]);
endmodule

// File: rtl/irq_status_dp.sv
module irq_status_dp
  import irq_status_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  ctrlStrobeT         strobes,
  output logic [DATA_W-1:0]  rdData,
  output logic               pending
);
  logic [NUM_EVT-1:0] causes;
  logic [NUM_EVT-1:0] admitted;

  assign admitted = evtPulse & strobes.evtGate;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_cause
    logic bitQ;
    always_ff @(posedge clk) begin
      if (rst) bitQ <= 1'b0;
      else     bitQ <= (bitQ && !strobes.readHit) || admitted[g];
    end
    assign causes[g] = bitQ;
  end

  assign pending = |causes;
  assign rdData  = strobes.readHit ? packWord(causes) : '0;

  // R5: an admitted event during a clearing read survives the clear
  a_r5_event_kept: assert property (@(posedge clk) disable iff (rst)
    (strobes.readHit && (admitted != '0)) |=>
      ((causes & $past(admitted)) == $past(admitted)));

  // R4: a read with no new event leaves nothing latched
  a_r4_read_clears: assert property (@(posedge clk) disable iff (rst)
    (strobes.readHit && (admitted == '0)) |=> (causes == '0));

  // R2: without a read, latched bits never drop
  a_r2_sticky: assert property (@(posedge clk) disable iff (rst)
    !strobes.readHit |=> ((causes & $past(causes)) == $past(causes)));
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
  import irq_status_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int REG_ADDR = 26,
  parameter int ABIL_W   = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_EVT-1:0] evtPulse,
  input  logic               anegEnable,
  input  logic [ABIL_W-1:0]  advAbility,
  input  logic               rdStrobe,
  input  logic [ADDR_W-1:0]  rdAddr,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqN
);
  ctrlStrobeT strobes;
  logic       pending;

  irq_status_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .ABIL_W(ABIL_W)) u_ctrl (
    .clk(clk), .rst(rst), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .anegEnable(anegEnable), .advAbility(advAbility), .strobes(strobes)
  );

  irq_status_dp u_dp (
    .clk(clk), .rst(rst), .evtPulse(evtPulse), .strobes(strobes),
    .rdData(rdData), .pending(pending)
  );

  assign irqN = !pending;

  // R10: the line agrees with the summary bit whenever the word is read
  a_r10_irq_line: assert property (@(posedge clk) disable iff (rst)
    (rdStrobe && rdAddr == ADDR_W'(REG_ADDR)) |-> (rdData[15] == !irqN));
endmodule

// File: tb/tb_irq_status_reg.sv
module tb_irq_status_reg;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  evtPulse;
  logic        anegEnable;
  logic [3:0]  advAbility;
  logic        rdStrobe;
  logic [4:0]  rdAddr;
  logic [15:0] rdData;
  logic        irqN;

  int checks = 0;
  int fails  = 0;
  logic [15:0] model = '0;

  always #10 clk = ~clk;

  irq_status_reg dut (
    .clk(clk), .rst(rst), .evtPulse(evtPulse), .anegEnable(anegEnable),
    .advAbility(advAbility), .rdStrobe(rdStrobe), .rdAddr(rdAddr),
    .rdData(rdData), .irqN(irqN)
  );

  function automatic logic [15:0] evtToWord(input logic [7:0] e, input logic aneg,
                                            input logic [3:0] abil);
    logic [15:0] w;
    w = '0;
    w[14] = e[0] & aneg;
    w[13] = e[1];
    w[12] = e[2] & aneg;
    w[11] = e[3];
    w[10] = e[4];
    w[9]  = e[5];
    w[2]  = e[6] & (abil == 4'hF);
    w[0]  = e[7];
    return w;
  endfunction

  function automatic logic [15:0] withSummary(input logic [15:0] c);
    return {(c[14:0] != 0), c[14:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [7:0] e, input logic rd,
                      input logic [4:0] a, input logic aneg, input logic [3:0] abil);
    logic hit;
    @(negedge clk);
    evtPulse = e; rdStrobe = rd; rdAddr = a; anegEnable = aneg; advAbility = abil;
    #2;
    hit = rd && (a == 5'd26);
    check(tag, {16'h0, rdData}, {16'h0, hit ? withSummary(model) : 16'h0});
    if (hit) begin
      check("R9", {16'h0, rdData & 16'h01FA}, 32'h0);
      check("R6", {31'h0, rdData[15]}, {31'h0, model[14:0] != 0});
    end
    check("R10", {31'h0, irqN}, {31'h0, model[14:0] == 0});
    model = (hit ? 16'h0 : model) | evtToWord(e, aneg, abil);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst = 1'b1; evtPulse = '0; anegEnable = 1'b1; advAbility = 4'hF;
    rdStrobe = 1'b0; rdAddr = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    evtPulse = 8'hFF;
    @(negedge clk);
    evtPulse = '0; rdStrobe = 1'b1; rdAddr = 5'd26; #2;
    check("R1", {16'h0, rdData}, 32'h0);
    check("R1", {31'h0, irqN}, 32'h1);
    rst = 1'b0; rdStrobe = 1'b0;

    // R2: link event latches and persists
    step("R2", 8'h02, 0, 5'd0, 1, 4'hF);
    step("R2", 8'h00, 0, 5'd0, 1, 4'hF);
    step("R2", 8'h00, 1, 5'd26, 1, 4'hF);
    // R4: read again shows cleared word
    step("R4", 8'h00, 1, 5'd26, 1, 4'hF);
    // R4: wrong address does not clear
    step("R4", 8'h80, 0, 5'd0, 1, 4'hF);
    step("R3", 8'h00, 1, 5'd25, 1, 4'hF);
    step("R4", 8'h00, 1, 5'd26, 1, 4'hF);
    // R5: event coincident with clearing read
    step("R5", 8'h08, 0, 5'd0, 1, 4'hF);
    step("R5", 8'h10, 1, 5'd26, 1, 4'hF);
    step("R5", 8'h00, 1, 5'd26, 1, 4'hF);
    // R7: speed and duplex ignored without auto-negotiation
    step("R7", 8'h05, 0, 5'd0, 0, 4'hF);
    step("R7", 8'h00, 1, 5'd26, 0, 4'hF);
    step("R7", 8'h05, 0, 5'd0, 1, 4'hF);
    step("R7", 8'h00, 1, 5'd26, 1, 4'hF);
    // R8: downshift needs the full ability field
    step("R8", 8'h40, 0, 5'd0, 1, 4'h7);
    step("R8", 8'h00, 1, 5'd26, 1, 4'h7);
    step("R8", 8'h40, 0, 5'd0, 1, 4'hF);
    step("R8", 8'h00, 1, 5'd26, 1, 4'hF);

    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] e;
      logic rd;
      logic [4:0] a;
      e  = 8'($urandom) & 8'($urandom) & 8'($urandom);
      rd = ($urandom % 4) == 0;
      a  = (($urandom % 4) != 0) ? 5'd26 : 5'($urandom);
      step("R3", e, rd, a, 1'($urandom), (($urandom % 3) != 0) ? 4'hF : 4'($urandom));
    end
    step("R3", 8'h00, 1, 5'd26, 1, 4'hF);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule